// File: doc/BRIEF.md
# Branch Trace Message Generator

This block watches the stream of instructions that a processor core retires and turns it into a compressed record of program flow. Sequential instructions produce no output. The block only counts them. A direct branch produces a short record that holds only the count of instructions since the previous record. An indirect jump, an interrupt entry or an exception entry produces a record that holds the count and the full destination address. That address becomes the new reference point for later relative records. Synchronisation records carry a full address. They give the host a fresh anchor after trace is enabled, after reset, after the downstream queue reports a lost record, and whenever the counter would otherwise wrap.

For every retired instruction, the core supplies its kind and the address of the instruction that executes after it. Each record goes out for one cycle on a flat record bus to a packetizer. The trace logic has its own reset and enable, separate from the core. A debugger can therefore arm tracing while the core is still held in reset, and the first instruction the core retires is reported with a full address.

Top module: `branch_trace_gen`

## Requirements
- R1: When tracing is enabled and no record is due, a cycle with no retired instruction or with a sequential retirement (`ret_kind` = 0) produces no record (`msg_vld` = 0).
- R2: A direct branch retirement (`ret_kind` = 1) with no sync due produces a record with code 3. Its count field equals the number of retirements since the previous record, the branch included, and its address field is 0.
- R3: An indirect retirement (`ret_kind` = 2 for an indirect jump, 3 for an interrupt or exception entry) always produces a record with code 4, the count, and `ret_npc` as address. This holds even when a sync is due, and the record satisfies that pending sync.
- R4: After trace reset, the first retirement that is not indirect produces a sync record: code 9, count of retirements since the previous record (1 for the first), and `ret_npc` as address. A direct branch with a sync due is reported this way.
- R5: After any record the instruction count restarts from zero. Cycles without a retirement do not advance it.
- R6: If a retirement that is not a branch would bring the count to 2^CNT_W-1, a sync record with that count and `ret_npc` is emitted at once. The count then restarts.
- R7: A `q_drop` pulse makes the next retirement produce a record with a full address: sync, or indirect if that retirement is indirect.
- R8: While `trc_en` is low, no record is produced and retirements are discarded. The first retirement after re-enabling follows R4.
- R9: During trace reset all record outputs are 0, and the instruction count is cleared.
- R10: A record appears on the outputs in the cycle after the retirement that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| trc_rst_n | input | 1 | Trace logic reset, active low, asynchronous, independent of the core reset |
| trc_en | input | 1 | Trace enable |
| ret_vld | input | 1 | One instruction retires this cycle |
| ret_kind | input | 2 | 0 sequential, 1 direct branch, 2 indirect jump, 3 interrupt/exception entry |
| ret_npc | input | ADDR_W | Address of the instruction executed next |
| q_drop | input | 1 | Downstream queue lost a record |
| msg_vld | output | 1 | Record valid for this cycle |
| msg_code | output | CODE_W | Transfer code: 3 direct, 4 indirect, 9 sync; 0 when idle |
| msg_cnt | output | CNT_W | Instructions since previous record, this one included; 0 when idle |
| msg_addr | output | ADDR_W | Full address for indirect and sync records; 0 otherwise |

## Verification
The bench builds the block with CNT_W = 3 and ADDR_W = 16. With these values the counter saturates after six plain instructions, so sweeping run lengths from 0 to 9 against every branch kind exercises both the relative records and the forced sync within a few dozen cycles each. The sweep interleaves idle cycles, queue-loss pulses, enable toggling and a trace reset in the middle of a run. Each case checks the whole record against counts and addresses derived arithmetically in the bench.

// File: rtl/branch_trace_gen.sv
module branch_trace_gen #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 8,
  parameter int CODE_W      = 6,
  parameter int TC_DIRECT   = 3,
  parameter int TC_INDIRECT = 4,
  parameter int TC_SYNC     = 9
) (
  input  logic              clk,
  input  logic              trc_rst_n,
  input  logic              trc_en,
  input  logic              ret_vld,
  input  logic [1:0]        ret_kind,
  input  logic [ADDR_W-1:0] ret_npc,
  input  logic              q_drop,
  output logic              msg_vld,
  output logic [CODE_W-1:0] msg_code,
  output logic [CNT_W-1:0]  msg_cnt,
  output logic [ADDR_W-1:0] msg_addr
);

  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [CODE_W-1:0] C_DIR   = CODE_W'(TC_DIRECT);
  localparam logic [CODE_W-1:0] C_IND   = CODE_W'(TC_INDIRECT);
  localparam logic [CODE_W-1:0] C_SYNC  = CODE_W'(TC_SYNC);

  logic [CNT_W-1:0]  cnt;
  logic              sync_pend;
  logic              take, far, dir, sat, emit, full;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CODE_W-1:0] code;

  assign take    = trc_en & ret_vld;
  assign far     = ret_kind[1];
  assign dir     = (ret_kind == 2'b01);
  assign cnt_inc = cnt + 1'b1;
  assign sat     = (cnt_inc == CNT_MAX);
  assign full    = sync_pend | far | (sat & ~dir);
  assign emit    = take & (full | dir);
  assign code    = far ? C_IND : (full ? C_SYNC : C_DIR);

  always_ff @(posedge clk or negedge trc_rst_n) begin
    if (!trc_rst_n) begin
      cnt       <= '0;
      sync_pend <= 1'b1;
      msg_vld   <= 1'b0;
      msg_code  <= '0;
      msg_cnt   <= '0;
      msg_addr  <= '0;
    end else begin
      msg_vld   <= emit;
      msg_code  <= emit ? code : '0;
      msg_cnt   <= emit ? cnt_inc : '0;
      msg_addr  <= (emit & full) ? ret_npc : '0;
      if (!trc_en || emit) cnt <= '0;
      else if (take)       cnt <= cnt_inc;
      sync_pend <= ~trc_en | q_drop | (sync_pend & ~emit);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!trc_rst_n)
    !(ret_vld && trc_en) |=> !msg_vld);

  p_direct_form_r2: assert property (@(posedge clk) disable iff (!trc_rst_n)
    (msg_vld && msg_code == C_DIR) |-> (msg_addr == '0 && msg_cnt != '0));

  p_indirect_full_r3: assert property (@(posedge clk) disable iff (!trc_rst_n)
    (ret_vld && trc_en && ret_kind[1]) |=> (msg_vld && msg_code == C_IND && msg_addr == $past(ret_npc)));

  p_pending_full_r4: assert property (@(posedge clk) disable iff (!trc_rst_n)
    (sync_pend && ret_vld && trc_en) |=> (msg_vld && msg_code != C_DIR));

  p_count_started_r5: assert property (@(posedge clk) disable iff (!trc_rst_n)
    msg_vld |-> msg_cnt != '0);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!trc_rst_n)
    cnt != CNT_MAX);

  p_drop_arms_r7: assert property (@(posedge clk) disable iff (!trc_rst_n)
    q_drop |=> sync_pend);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!trc_rst_n)
    !trc_en |=> (!msg_vld && cnt == '0));

  p_code_legal_r10: assert property (@(posedge clk) disable iff (!trc_rst_n)
    msg_vld |-> (msg_code == C_DIR || msg_code == C_IND || msg_code == C_SYNC));

endmodule

// File: tb/branch_trace_gen_test.sv
`timescale 1ns/1ps
module branch_trace_gen_test;
  localparam int AW = 16;
  localparam int CW = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, vld = 1'b0, drop = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [AW-1:0] npc = '0;
  logic msg_vld;
  logic [5:0] msg_code;
  logic [CW-1:0] msg_cnt;
  logic [AW-1:0] msg_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_cnt = 0;
  bit m_pend = 1;
  string m_why = "R4";

  always #2 clk = ~clk;

  branch_trace_gen #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .trc_rst_n(rst_n), .trc_en(en), .ret_vld(vld), .ret_kind(kind),
    .ret_npc(npc), .q_drop(drop), .msg_vld(msg_vld), .msg_code(msg_code),
    .msg_cnt(msg_cnt), .msg_addr(msg_addr));

  task automatic chk(input string tag, input logic [25:0] act, input logic [25:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic v, input logic [1:0] k,
                     input logic [AW-1:0] a, input logic d);
    int inc;
    bit take, far, dir, sat, full, emit;
    logic [25:0] exp;
    string tag;
    en = e; vld = v; kind = k; npc = a; drop = d;
    take = e && v;
    inc  = m_cnt + 1;
    far  = k[1];
    dir  = (k == 2'd1);
    sat  = (inc == MAXC);
    full = m_pend || far || (sat && !dir);
    emit = take && (full || dir);
    if (emit)
      exp = {1'b1, far ? 6'd4 : (full ? 6'd9 : 6'd3), CW'(inc), full ? a : AW'(0)};
    else
      exp = '0;
    if (!emit)        tag = e ? "R1" : "R8";
    else if (far)     tag = "R3 R10";
    else if (!full)   tag = "R2 R5";
    else if (m_pend)  tag = m_why;
    else              tag = "R6";
    if (!e || emit)   m_cnt = 0;
    else if (take)    m_cnt = inc;
    if (!e)           m_why = "R8";
    else if (d)       m_why = "R7";
    m_pend = !e || d || (m_pend && !emit);
    @(posedge clk); #1;
    chk(tag, {msg_vld, msg_code, msg_cnt, msg_addr}, exp);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R9", {msg_vld, msg_code, msg_cnt, msg_addr}, '0);
    en = 1'b1; vld = 1'b1;
    @(posedge clk); #1;
    chk("R9", {msg_vld, msg_code, msg_cnt, msg_addr}, '0);
    vld = 1'b0;
    rst_n = 1'b1;
    m_cnt = 0; m_pend = 1; m_why = "R4";
    cyc(1, 0, 0, 16'h0, 0);
    cyc(1, 0, 0, 16'h0, 0);
    cyc(1, 1, 0, 16'h0100, 0);

    for (int L = 0; L < 10; L++)
      for (int k = 1; k < 4; k++) begin
        for (int i = 0; i < L; i++) begin
          cyc(1, 1, 2'd0, 16'(16'h0200 + L * 64 + k * 16 + i), 0);
          if (i % 3 == 2) cyc(1, 0, 2'd0, 16'h0, 0);
        end
        cyc(1, 1, 2'(k), 16'(16'h4000 + L * 97 + k * 13), 0);
      end

    for (int p = 0; p < 4; p++) begin
      cyc(1, 1, 2'd0, 16'(16'h0700 + p), 0);
      cyc(1, p[0], 2'd0, 16'(16'h0710 + p), 1);
      cyc(1, 0, 2'd0, 16'h0, 0);
      cyc(1, 1, 2'(p == 3 ? 2 : p[1]), 16'(16'h0720 + p), 0);
      cyc(1, 1, 2'd0, 16'(16'h0730 + p), 0);
      cyc(1, 1, 2'd1, 16'(16'h0740 + p), 0);
    end

    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 2'd0, 16'h0800, 0);
      cyc(0, 1, 2'(k), 16'h0810, 0);
      cyc(0, 1, 2'd1, 16'h0820, 1);
      cyc(0, 0, 2'd0, 16'h0, 0);
      cyc(1, 1, 2'(k), 16'(16'h0830 + k), 0);
      cyc(1, 1, 2'd1, 16'h0840, 0);
    end

    cyc(1, 1, 2'd0, 16'h0900, 0);
    cyc(1, 0, 2'd0, 16'h0, 0);
    en = 1'b1; vld = 1'b1; kind = 2'd1; npc = 16'h0910; drop = 1'b0;
    #1;
    chk("R10", {25'd0, msg_vld}, 26'd0);
    @(posedge clk); #1;
    chk("R10 R2", {msg_vld, msg_code, msg_cnt, msg_addr}, {1'b1, 6'd3, 3'd2, 16'd0});
    m_cnt = 0;

    cyc(1, 1, 2'd0, 16'h0a00, 0);
    cyc(1, 1, 2'd0, 16'h0a01, 0);
    vld = 1'b0;
    rst_n = 1'b0; #1;
    chk("R9", {msg_vld, msg_code, msg_cnt, msg_addr}, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    m_cnt = 0; m_pend = 1; m_why = "R4 R9";
    cyc(1, 1, 2'd1, 16'h0a10, 0);
    cyc(1, 1, 2'd1, 16'h0a20, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule